// File: doc/BRIEF.md
# Sensor Acquisition Mode Controller

This block decides when a sensor front end should take a measurement and when the host-visible output registers change. The host writes a control byte that selects an acquisition rate, turns block-data-update on or off and fires single measurements. The controller raises a one-cycle request to the front end, either on its own at the selected rate or once per single-shot trigger. When a conversion finishes, the front end returns a pressure word and a temperature word on a valid/ready stream.

Completed samples are published in five byte-wide output registers. With block-data-update off, every sample overwrites them. With it on, the first read of a pressure or temperature byte freezes the set. Samples that arrive while the set is frozen go to a shadow copy. Reading the high pressure byte lifts the freeze, and the newest shadowed sample then moves into the outputs. Rate timing is counted from a 1 kHz tick input.

The sample stream has no back-pressure: `smp_ready` is held high. A beat is taken on every cycle in which `smp_valid` is high, whatever mode the block is in.

Top module: `acq_mode_ctrl`

## Requirements
- R1: After reset the control register reads 0x00, all five output bytes read 0x00, and no request is issued while the rate field stays at 000.
- R2: Control register (address 0x0) layout: rate field in bits 6:4, block-data-update in bit 1, single-shot trigger in bit 0. Bits 7, 3 and 2 always read 0, whatever is written to them.
- R3: With rate code 001/010/011/100/101, `acq_req` pulses once every 1000/100/40/20/13 ticks. The first pulse comes that many ticks after the control write.
- R4: Rate codes 000, 110 and 111 are power-down. No request is issued, and the output bytes keep their last values.
- R5: Writing bit 0 = 1 together with a power-down rate code gives exactly one `acq_req` pulse, on the cycle after the write. Bit 0 then reads 1 until a sample is accepted, and reads 0 after that. Re-triggering while a measurement is pending gives no further pulse.
- R6: A single-shot write carrying a non-power-down rate code is ignored, and bit 0 reads 0. Writing a non-power-down rate also cancels a pending single shot.
- R7: With block-data-update off, each accepted sample overwrites the output bytes. Address map: 0x4/0x5/0x6 are pressure bits 7:0, 15:8 and 23:16; 0x7/0x8 are temperature bits 7:0 and 15:8. Other addresses read 0x00.
- R8: With block-data-update on, reading 0x4, 0x5, 0x7 or 0x8 freezes the output bytes. They stay frozen until 0x6 is read or block-data-update is written to 0. The read of 0x6 itself still returns the frozen byte.
- R9: Samples accepted while frozen are not lost. The newest one appears in the outputs on the cycle after the freeze lifts.
- R10: `smp_ready` is always high, and a sample is taken on every cycle with `smp_valid` high.
- R11: Every write to the control register restarts the rate counter.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_addr | input | 4 | Host register address |
| reg_wdata | input | 8 | Host write data |
| reg_wr | input | 1 | Write strobe, one cycle per write |
| reg_rd | input | 1 | Read strobe, one cycle per read |
| reg_rdata | output | 8 | Read data for `reg_addr`, combinational |
| tick_1k | input | 1 | Timebase tick, one cycle high per tick |
| acq_req | output | 1 | One-cycle acquisition request |
| smp_valid | input | 1 | Sample beat valid |
| smp_ready | output | 1 | Sample beat ready (constant high) |
| smp_press | input | 24 | Pressure word of the beat |
| smp_temp | input | 16 | Temperature word of the beat |

## Verification
The bench measures the spacing of request pulses, both from the control write and between pulses, for every rate code. It rewrites the rate in the middle of a period: a counter that ignores the rewrite would pulse early. It drives single shots with a power-down rate and with a running rate, and re-triggers one that is still pending, to catch a bit that sticks, never clears or fires twice. It sends several samples during a freeze and then lifts the freeze both by the release read and by clearing block-data-update. A design that drops the shadow, keeps the oldest sample or leaks new bytes into a frozen set then returns wrong bytes.

// File: rtl/acq_pkg.sv
`timescale 1ns/1ps
package acq_pkg;
  localparam int unsigned ADDR_W  = 4;
  localparam int unsigned PRESS_W = 24;
  localparam int unsigned TEMP_W  = 16;
  localparam int unsigned RATE_W  = 3;

  localparam logic [ADDR_W-1:0] ADR_CTRL = 4'h0;
  localparam logic [ADDR_W-1:0] ADR_P0   = 4'h4;
  localparam logic [ADDR_W-1:0] ADR_P1   = 4'h5;
  localparam logic [ADDR_W-1:0] ADR_P2   = 4'h6;
  localparam logic [ADDR_W-1:0] ADR_T0   = 4'h7;
  localparam logic [ADDR_W-1:0] ADR_T1   = 4'h8;

  // control byte field positions
  localparam int unsigned CB_RATE_LO = 4;
  localparam int unsigned CB_BDU     = 1;
  localparam int unsigned CB_SHOT    = 0;

  // codes 000, 110 and 111 all mean power-down
  function automatic logic rate_off(input logic [RATE_W-1:0] r);
    return (r == 3'd0) || (r > 3'd5);
  endfunction
endpackage

// File: rtl/acq_ctrl_reg.sv
`timescale 1ns/1ps
module acq_ctrl_reg
  import acq_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [RATE_W-1:0] w_rate,
  input  logic              w_bdu,
  input  logic              w_shot,
  input  logic              smp_take,
  output logic [RATE_W-1:0] rate,
  output logic              bdu,
  output logic              shot_fire,
  output logic [7:0]        rdata
);
  logic shot_pend;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rate      <= '0;
      bdu       <= 1'b0;
      shot_pend <= 1'b0;
      shot_fire <= 1'b0;
    end else begin
      shot_fire <= 1'b0;
      if (wr_en) begin
        rate <= w_rate;
        bdu  <= w_bdu;
      end
      if (wr_en && !rate_off(w_rate)) begin
        shot_pend <= 1'b0;                 // running mode cancels a shot
      end else if (wr_en && w_shot && !shot_pend) begin
        shot_pend <= 1'b1;
        shot_fire <= 1'b1;
      end else if (smp_take) begin
        shot_pend <= 1'b0;                 // self-clear on completion
      end
    end
  end

  always_comb begin
    rdata            = '0;
    rdata[6:4]       = rate;
    rdata[CB_BDU]    = bdu;
    rdata[CB_SHOT]   = shot_pend;
  end

  // R5: a pending shot only exists while in power-down
  p_shot_only_off_r5: assert property (@(posedge clk) disable iff (!rst_n)
    shot_pend |-> rate_off(rate));
  // R5: one request per trigger
  p_shot_single_r5: assert property (@(posedge clk) disable iff (!rst_n)
    shot_fire |=> !shot_fire);
  p_shot_fire_pend_r5: assert property (@(posedge clk) disable iff (!rst_n)
    shot_fire |-> shot_pend);
endmodule

// File: rtl/acq_rate_timer.sv
`timescale 1ns/1ps
module acq_rate_timer
  import acq_pkg::*;
#(
  parameter int unsigned TICK_HZ = 1000,
  localparam int unsigned CNT_W  = $clog2(TICK_HZ + 1)
)(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic              restart,
  input  logic [RATE_W-1:0] rate,
  output logic              fire
);
  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] lim;
  logic             off;

  assign off = rate_off(rate);

  always_comb begin
    case (rate)
      3'd1:    lim = CNT_W'(TICK_HZ / 1  - 1);
      3'd2:    lim = CNT_W'(TICK_HZ / 10 - 1);
      3'd3:    lim = CNT_W'(TICK_HZ / 25 - 1);
      3'd4:    lim = CNT_W'(TICK_HZ / 50 - 1);
      3'd5:    lim = CNT_W'(TICK_HZ / 75 - 1);
      default: lim = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt  <= '0;
      fire <= 1'b0;
    end else if (restart || off) begin
      cnt  <= '0;
      fire <= 1'b0;
    end else if (tick) begin
      if (cnt >= lim) begin
        cnt  <= '0;
        fire <= 1'b1;
      end else begin
        cnt  <= cnt + 1'b1;
        fire <= 1'b0;
      end
    end else begin
      fire <= 1'b0;
    end
  end

  // R4: power-down never produces a request
  p_quiet_off_r4: assert property (@(posedge clk) disable iff (!rst_n)
    off |=> !fire);
  // R3: rate requests are single-cycle pulses
  p_fire_pulse_r3: assert property (@(posedge clk) disable iff (!rst_n)
    fire |=> !fire);
  // R11: a control write suppresses the next-cycle pulse and zeroes the count
  p_restart_r11: assert property (@(posedge clk) disable iff (!rst_n)
    restart |=> (!fire && cnt == '0));
endmodule

// File: rtl/acq_out_bank.sv
`timescale 1ns/1ps
module acq_out_bank
  import acq_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               bdu,
  input  logic               rd_arm,
  input  logic               rd_release,
  input  logic               smp_take,
  input  logic [PRESS_W-1:0] smp_press,
  input  logic [TEMP_W-1:0]  smp_temp,
  output logic [PRESS_W-1:0] out_press,
  output logic [TEMP_W-1:0]  out_temp
);
  logic               lock;
  logic               hold;
  logic               sh_v;
  logic [PRESS_W-1:0] sh_press;
  logic [TEMP_W-1:0]  sh_temp;

  // the release read lifts the hold in its own cycle
  assign hold = bdu && lock && !rd_release;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lock <= 1'b0;
    end else if (!bdu || rd_release) begin
      lock <= 1'b0;
    end else if (rd_arm) begin
      lock <= 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_press <= '0;
      out_temp  <= '0;
      sh_press  <= '0;
      sh_temp   <= '0;
      sh_v      <= 1'b0;
    end else if (smp_take) begin
      if (hold) begin
        sh_press <= smp_press;
        sh_temp  <= smp_temp;
        sh_v     <= 1'b1;
      end else begin
        out_press <= smp_press;
        out_temp  <= smp_temp;
        sh_v      <= 1'b0;
      end
    end else if (!hold && sh_v) begin
      out_press <= sh_press;
      out_temp  <= sh_temp;
      sh_v      <= 1'b0;
    end
  end

  // R8: frozen outputs do not move
  p_frozen_r8: assert property (@(posedge clk) disable iff (!rst_n)
    hold |=> ($stable(out_press) && $stable(out_temp)));
  // R9: a waiting shadow drains as soon as the hold lifts
  p_drain_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (!hold && sh_v) |=> !sh_v);
endmodule

// File: rtl/acq_mode_ctrl.sv
`timescale 1ns/1ps
module acq_mode_ctrl
  import acq_pkg::*;
#(
  parameter int unsigned TICK_HZ = 1000
)(
  input  logic        clk,
  input  logic        rst_n,
  input  logic [3:0]  reg_addr,
  input  logic [7:0]  reg_wdata,
  input  logic        reg_wr,
  input  logic        reg_rd,
  output logic [7:0]  reg_rdata,
  input  logic        tick_1k,
  output logic        acq_req,
  input  logic        smp_valid,
  output logic        smp_ready,
  input  logic [23:0] smp_press,
  input  logic [15:0] smp_temp
);
  logic              ctrl_wr;
  logic              smp_take;
  logic [RATE_W-1:0] rate;
  logic              bdu;
  logic              shot_fire;
  logic              tmr_fire;
  logic [7:0]        ctrl_rdata;
  logic              rd_arm;
  logic              rd_release;
  logic [PRESS_W-1:0] out_press;
  logic [TEMP_W-1:0]  out_temp;
  logic              unused_wbits;

  assign unused_wbits = ^{reg_wdata[7], reg_wdata[3:2]};
  assign ctrl_wr   = reg_wr && (reg_addr == ADR_CTRL);
  assign smp_ready = 1'b1;
  assign smp_take  = smp_valid && smp_ready;

  acq_ctrl_reg u_ctrl (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_en     (ctrl_wr),
    .w_rate    (reg_wdata[6:4]),
    .w_bdu     (reg_wdata[CB_BDU]),
    .w_shot    (reg_wdata[CB_SHOT]),
    .smp_take  (smp_take),
    .rate      (rate),
    .bdu       (bdu),
    .shot_fire (shot_fire),
    .rdata     (ctrl_rdata)
  );

  acq_rate_timer #(.TICK_HZ(TICK_HZ)) u_timer (
    .clk     (clk),
    .rst_n   (rst_n),
    .tick    (tick_1k),
    .restart (ctrl_wr),
    .rate    (rate),
    .fire    (tmr_fire)
  );

  assign rd_release = reg_rd && (reg_addr == ADR_P2);
  assign rd_arm     = reg_rd && bdu &&
                      ((reg_addr == ADR_P0) || (reg_addr == ADR_P1) ||
                       (reg_addr == ADR_T0) || (reg_addr == ADR_T1));

  acq_out_bank u_bank (
    .clk        (clk),
    .rst_n      (rst_n),
    .bdu        (bdu),
    .rd_arm     (rd_arm),
    .rd_release (rd_release),
    .smp_take   (smp_take),
    .smp_press  (smp_press),
    .smp_temp   (smp_temp),
    .out_press  (out_press),
    .out_temp   (out_temp)
  );

  assign acq_req = shot_fire || tmr_fire;

  always_comb begin
    case (reg_addr)
      ADR_CTRL: reg_rdata = ctrl_rdata;
      ADR_P0:   reg_rdata = out_press[7:0];
      ADR_P1:   reg_rdata = out_press[15:8];
      ADR_P2:   reg_rdata = out_press[23:16];
      ADR_T0:   reg_rdata = out_temp[7:0];
      ADR_T1:   reg_rdata = out_temp[15:8];
      default:  reg_rdata = 8'h00;
    endcase
  end

  // R2: reserved control bits never read back set
  p_rsvd_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_addr == ADR_CTRL) |-> (reg_rdata[7] == 1'b0 && reg_rdata[3:2] == 2'b00));
  // R10: the stream never back-pressures
  p_ready_r10: assert property (@(posedge clk) disable iff (!rst_n)
    smp_valid |-> smp_ready);
endmodule

// File: tb/acq_mode_ctrl_bench.sv
`timescale 1ns/1ps
module acq_mode_ctrl_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [3:0]  reg_addr = '0;
  logic [7:0]  reg_wdata = '0;
  logic        reg_wr = 1'b0;
  logic        reg_rd = 1'b0;
  logic [7:0]  reg_rdata;
  logic        tick_1k = 1'b1;
  logic        acq_req;
  logic        smp_valid = 1'b0;
  logic        smp_ready;
  logic [23:0] smp_press = '0;
  logic [15:0] smp_temp = '0;

  int n_chk = 0;
  int n_err = 0;
  int cyc = 0;
  int wr_cyc = 0;
  int first_req = -1;
  int last_req = 0;
  int prev_req = 0;
  int req_cnt = 0;
  bit done = 1'b0;

  typedef struct { logic [7:0] val; string tag; } exp_t;
  exp_t exp_q[$];

  always #4 clk = ~clk;

  acq_mode_ctrl u_acq_mode_ctrl (
    .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_rdata(reg_rdata), .tick_1k(tick_1k),
    .acq_req(acq_req), .smp_valid(smp_valid), .smp_ready(smp_ready),
    .smp_press(smp_press), .smp_temp(smp_temp)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  // monitor: request timing and read scoreboard
  always @(negedge clk) begin
    cyc++;
    if (reg_wr && reg_addr == 4'h0) begin
      wr_cyc = cyc;
      first_req = -1;
    end
    if (acq_req) begin
      req_cnt++;
      prev_req = last_req;
      last_req = cyc;
      if (first_req < 0) first_req = cyc;
    end
    if (reg_rd && rst_n) begin
      if (exp_q.size() == 0) begin
        chk(1'b0, "scoreboard empty", reg_rdata, 0);
      end else begin
        exp_t e;
        e = exp_q.pop_front();
        chk(reg_rdata === e.val, e.tag, reg_rdata, e.val);
      end
    end
  end

  task automatic idle(input int n);
    repeat (n) @(posedge clk);
  endtask

  task automatic wr_ctrl(input logic [7:0] d);
    @(posedge clk); #2;
    reg_addr = 4'h0; reg_wdata = d; reg_wr = 1'b1;
    @(posedge clk); #2;
    reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, input logic [7:0] v, input string tag);
    exp_t e;
    @(posedge clk); #2;
    e.val = v; e.tag = tag;
    exp_q.push_back(e);
    reg_addr = a; reg_rd = 1'b1;
    @(posedge clk); #2;
    reg_rd = 1'b0;
  endtask

  task automatic send(input logic [23:0] p, input logic [15:0] t);
    @(posedge clk); #2;
    smp_valid = 1'b1; smp_press = p; smp_temp = t;
    chk(smp_ready === 1'b1, "R10 ready high", smp_ready, 1);
    @(posedge clk); #2;
    smp_valid = 1'b0;
  endtask

  task automatic rd_all(input logic [23:0] p, input logic [15:0] t, input string tag);
    rd(4'h4, p[7:0], tag);
    rd(4'h5, p[15:8], tag);
    rd(4'h7, t[7:0], tag);
    rd(4'h8, t[15:8], tag);
    rd(4'h6, p[23:16], tag);
  endtask

  task automatic rate_case(input logic [2:0] code, input int per);
    wr_ctrl({1'b0, code, 4'b0000});
    idle(2 * per + 10);
    chk(first_req - wr_cyc == per + 1, "R3 first pulse after write", first_req - wr_cyc, per + 1);
    chk(last_req - prev_req == per, "R3 pulse spacing", last_req - prev_req, per);
  endtask

  initial begin
    int base;
    idle(5);
    #2 rst_n = 1'b1;
    // R1 reset state
    rd(4'h0, 8'h00, "R1 ctrl after reset");
    rd_all(24'h0, 16'h0, "R1 outputs after reset");
    idle(50);
    chk(req_cnt == 0, "R1 no request after reset", req_cnt, 0);
    // R2 / R6: reserved bits, shot ignored in running mode
    wr_ctrl(8'hBF);
    rd(4'h0, 8'h32, "R2 R6 ctrl readback");
    idle(10);
    rd(4'h9, 8'h00, "R7 unmapped address");
    // R3 every running rate
    rate_case(3'd3, 40);
    rate_case(3'd4, 20);
    rate_case(3'd5, 13);
    rate_case(3'd2, 100);
    rate_case(3'd1, 1000);
    // R11 restart mid-period
    wr_ctrl(8'h40);
    idle(10);
    wr_ctrl(8'h40);
    idle(30);
    chk(first_req - wr_cyc == 21, "R11 counter restarted", first_req - wr_cyc, 21);
    // R4 power-down codes
    wr_ctrl(8'h00);
    base = req_cnt;
    idle(1100);
    chk(req_cnt == base, "R4 code 000 quiet", req_cnt - base, 0);
    wr_ctrl(8'h60);
    idle(300);
    wr_ctrl(8'h70);
    idle(300);
    chk(req_cnt == base, "R4 codes 110/111 quiet", req_cnt - base, 0);
    rd_all(24'h0, 16'h0, "R4 outputs kept");
    // R5 single shot
    wr_ctrl(8'h01);
    idle(3);
    chk(first_req - wr_cyc == 1, "R5 shot pulse next cycle", first_req - wr_cyc, 1);
    rd(4'h0, 8'h01, "R5 shot bit pending");
    wr_ctrl(8'h01);
    idle(20);
    chk(req_cnt == base + 1, "R5 one pulse per shot", req_cnt - base, 1);
    send(24'h123456, 16'hABCD);
    rd(4'h0, 8'h00, "R5 shot bit self-cleared");
    rd_all(24'h123456, 16'hABCD, "R5 R7 shot sample published");
    idle(20);
    chk(req_cnt == base + 1, "R5 back in power-down", req_cnt - base, 1);
    // R6 running rate cancels a pending shot
    wr_ctrl(8'h01);
    wr_ctrl(8'h41);
    rd(4'h0, 8'h40, "R6 shot cancelled");
    wr_ctrl(8'h00);
    // R7 overwrite without block-data-update
    send(24'h010203, 16'h0405);
    send(24'h0A0B0C, 16'h0D0E);
    rd(4'h4, 8'h0C, "R7 overwrite low");
    rd(4'h8, 8'h0D, "R7 overwrite temp high");
    // R8 / R9 freeze and shadow
    wr_ctrl(8'h02);
    rd(4'h0, 8'h02, "R2 bdu bit");
    send(24'h112233, 16'h4455);
    rd(4'h4, 8'h33, "R8 arm read");
    send(24'h667788, 16'h99AA);
    send(24'hBBCCDD, 16'hEEFF);
    rd(4'h5, 8'h22, "R8 frozen mid");
    rd(4'h7, 8'h55, "R8 frozen temp low");
    rd(4'h8, 8'h44, "R8 frozen temp high");
    rd(4'h6, 8'h11, "R8 release read returns frozen");
    rd(4'h4, 8'hDD, "R9 newest shadow published");
    rd(4'h7, 8'hFF, "R9 newest temp");
    rd(4'h6, 8'hBB, "R9 newest high");
    send(24'h010101, 16'h0202);
    rd(4'h6, 8'h01, "R8 unfrozen after release");
    // R8 clearing bdu lifts the freeze
    wr_ctrl(8'h02);
    rd(4'h5, 8'h01, "R8 arm again");
    send(24'h5A5B5C, 16'h5D5E);
    rd(4'h4, 8'h01, "R8 still frozen");
    wr_ctrl(8'h00);
    rd(4'h4, 8'h5C, "R8 R9 bdu off releases");
    rd(4'h8, 8'h5D, "R9 temp after bdu off");
    idle(5);
    chk(exp_q.size() == 0, "scoreboard drained", exp_q.size(), 0);
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_err++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
    end
  end
endmodule